// File: doc/BRIEF.md
# NAND Page Program Sequencer

This block is the host side of a page write to an 8-bit asynchronous NAND flash device. A request carries the page row and the starting column. The sequencer then pulls data bytes from a valid/ready stream and writes each one into the device's page register. Any byte after the first may carry a new column. In that case the sequencer moves the device's load pointer to that column before writing the byte, so a caller can scatter bytes across the page and skip the ones that need no programming. The beat marked last closes the load and starts the device's internal programming.

Once programming has started, the sequencer waits for the ready/busy line to rise. It then reads the device status with a read-enable strobe and reports pass or fail through a one-cycle done pulse with a result code. If the device stays busy too long, the sequencer sends a reset command and reports a timeout. The strobe low and high widths and the busy limit are run-time inputs counted in clock cycles.

Top module: `nand_prog_seq`

## Requirements
- R1: An accepted request produces the command byte 0x80, then five address bytes in this order: column low byte, column high byte, row bits 7:0, row bits 15:8, row bits 23:16. A command byte has CLE=1 and ALE=0. An address byte has ALE=1 and CLE=0. The device takes each byte on the rising edge of WE#.
- R2: Data bytes go out with CLE=0 and ALE=0, in stream order. Every write strobe holds WE# low for `cfg_lo` cycles and high for `cfg_hi` cycles, and a value of 0 counts as 1.
- R3: A stream beat with `din_jump`=1 that is not the first beat of the request is written after the command byte 0x85 and two address bytes (`din_col` low byte, then high byte). On the first beat, `din_jump` has no effect: no 0x85 appears and the request column is kept.
- R4: The command 0x10 follows immediately after the data byte of the beat marked `din_last`. It is never issued before at least one data byte of the same request.
- R5: After 0x10 the sequencer waits a fixed settling time, then waits for `nand_rb_n` to be high. While the device may be busy, the only commands it issues are 0x70 and 0xFF.
- R6: On ready, it issues 0x70 once and then strobes RE# (low for `cfg_lo`, high for `cfg_hi`), sampling `nand_io_in` at the end of the low phase. If bit 6 is 0, it reads again without a new command. If bit 6 is 1, bit 0 selects `result` 0 (pass, bit 0 = 0) or 1 (fail, bit 0 = 1).
- R7: If `cfg_tmo` cycles pass while it waits for ready or polls status, it issues 0xFF and reports `result` 2 (timeout). No status read follows.
- R8: `req_ready` is high only when idle, and a request raised while an operation runs has no effect. CE# is low from the cycle after acceptance until the done cycle. `done` is high for exactly one cycle.
- R9: `nand_io_oe` is high only during write strobes. It is low whenever RE# is low, and WE# and RE# are never low together.
- R10: After reset the block is idle: `req_ready`=1, CE#, WE# and RE# are high, `nand_io_oe`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Start request |
| req_ready | output | 1 | Idle, request is taken |
| req_row | input | 24 | Page row address |
| req_col | input | 16 | Starting column |
| din_valid | input | 1 | Data beat valid |
| din_ready | output | 1 | Data beat taken |
| din_data | input | 8 | Data byte |
| din_col | input | 16 | New column for a jump beat |
| din_jump | input | 1 | Move load pointer before this byte |
| din_last | input | 1 | Final beat of the page |
| cfg_lo | input | 6 | Strobe low width in cycles |
| cfg_hi | input | 6 | Strobe high width in cycles |
| cfg_tmo | input | 20 | Busy limit in cycles |
| done | output | 1 | Operation finished (one cycle) |
| result | output | 2 | 0 pass, 1 fail, 2 timeout |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Byte driven to the device |
| nand_io_oe | output | 1 | Host drives the I/O bus |
| nand_io_in | input | 8 | Byte from the device |
| nand_rb_n | input | 1 | Ready (1) / busy (0) |

## Verification
Some rules hold on every cycle, and the assertions cover them: CLE and ALE are never both high, the host releases the bus during a read strobe, 0x10 never comes before a data byte, only 0x70 and 0xFF follow the confirm, CE# stays high while idle, and `done` lasts one cycle. Other behaviour can only be shown by the bench scenarios against its device model. These are the exact byte order for jumps and for an ignored first-beat jump, the strobe widths including a zero setting, repeated status polling, fail and timeout codes, and the absence of any effect from a request raised mid-operation.

// File: rtl/nand_prog_seq.sv
module nand_prog_seq #(
  parameter int CNT_W  = 6,
  parameter int TMO_W  = 20,
  parameter int ROW_W  = 24,
  parameter int COL_W  = 16,
  parameter int WB_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             din_valid,
  output logic             din_ready,
  input  logic [7:0]       din_data,
  input  logic [COL_W-1:0] din_col,
  input  logic             din_jump,
  input  logic             din_last,
  input  logic [CNT_W-1:0] cfg_lo,
  input  logic [CNT_W-1:0] cfg_hi,
  input  logic [TMO_W-1:0] cfg_tmo,
  output logic             done,
  output logic [1:0]       result,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_io_out,
  output logic             nand_io_oe,
  input  logic [7:0]       nand_io_in,
  input  logic             nand_rb_n
);
  localparam int COL_CYC = (COL_W + 7) / 8;
  localparam int ROW_CYC = (ROW_W + 7) / 8;
  localparam int COL_PW  = 8 * COL_CYC;
  localparam int ROW_PW  = 8 * ROW_CYC;
  localparam int ADR_N   = COL_CYC + ROW_CYC;
  localparam int AW      = 8 * ADR_N;
  localparam int IDX_W   = $clog2(ADR_N + 1);
  localparam logic [1:0] RES_PASS = 2'd0;
  localparam logic [1:0] RES_FAIL = 2'd1;
  localparam logic [1:0] RES_TMO  = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_WLO, S_WHI, S_DWAIT, S_WB, S_BUSY, S_RLO, S_RHI, S_DONE
  } st_t;

  typedef enum logic [2:0] {
    K_C80, K_ADR, K_DAT, K_C85, K_JAD, K_C10, K_C70, K_CFF
  } kind_t;

  st_t              st;
  kind_t            kind;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt;
  logic [TMO_W-1:0] tmo;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [7:0]       byte_q;
  logic             last_q, first_q, rdy_q, err_q;
  logic [1:0]       result_q;

  logic [CNT_W:0]   cnt_nx;
  logic [TMO_W:0]   tmo_nx;
  logic             lo_end, hi_end, tmo_hit, wr, is_cmd, is_adr;
  logic [AW-1:0]    addr_vec;
  logic [7:0]       adr_byte;
  logic             unused_io;

  assign cnt_nx   = {1'b0, cnt} + (CNT_W+1)'(1);
  assign tmo_nx   = {1'b0, tmo} + (TMO_W+1)'(1);
  assign lo_end   = cnt_nx >= {1'b0, cfg_lo};
  assign hi_end   = cnt_nx >= {1'b0, cfg_hi};
  assign tmo_hit  = tmo_nx >= {1'b0, cfg_tmo};
  assign addr_vec = {ROW_PW'(row_q), COL_PW'(col_q)};
  assign adr_byte = addr_vec[{idx, 3'b000} +: 8];
  assign unused_io = ^{nand_io_in[7], nand_io_in[5:1]};

  assign wr     = (st == S_WLO) || (st == S_WHI);
  assign is_cmd = kind inside {K_C80, K_C85, K_C10, K_C70, K_CFF};
  assign is_adr = kind inside {K_ADR, K_JAD};

  assign req_ready  = st == S_IDLE;
  assign din_ready  = st == S_DWAIT;
  assign done       = st == S_DONE;
  assign result     = result_q;
  assign nand_ce_n  = (st == S_IDLE) || (st == S_DONE);
  assign nand_cle   = wr && is_cmd;
  assign nand_ale   = wr && is_adr;
  assign nand_we_n  = st != S_WLO;
  assign nand_re_n  = st != S_RLO;
  assign nand_io_oe = wr;

  always_comb begin
    case (kind)
      K_C80:        nand_io_out = 8'h80;
      K_C85:        nand_io_out = 8'h85;
      K_C10:        nand_io_out = 8'h10;
      K_C70:        nand_io_out = 8'h70;
      K_CFF:        nand_io_out = 8'hFF;
      K_ADR, K_JAD: nand_io_out = adr_byte;
      default:      nand_io_out = byte_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      kind     <= K_C80;
      idx      <= '0;
      cnt      <= '0;
      tmo      <= '0;
      row_q    <= '0;
      col_q    <= '0;
      byte_q   <= '0;
      last_q   <= 1'b0;
      first_q  <= 1'b0;
      rdy_q    <= 1'b0;
      err_q    <= 1'b0;
      result_q <= RES_PASS;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          row_q   <= req_row;
          col_q   <= req_col;
          kind    <= K_C80;
          idx     <= '0;
          cnt     <= '0;
          first_q <= 1'b1;
          st      <= S_WLO;
        end
        S_WLO: if (lo_end) begin
          cnt <= '0;
          st  <= S_WHI;
        end else cnt <= cnt + 1'b1;
        S_WHI: if (!hi_end) cnt <= cnt + 1'b1;
        else begin
          cnt <= '0;
          case (kind)
            K_C80: begin kind <= K_ADR; idx <= '0; st <= S_WLO; end
            K_ADR: if (idx == IDX_W'(ADR_N - 1)) st <= S_DWAIT;
                   else begin idx <= idx + 1'b1; st <= S_WLO; end
            K_C85: begin kind <= K_JAD; idx <= '0; st <= S_WLO; end
            K_JAD: if (idx == IDX_W'(COL_CYC - 1)) begin kind <= K_DAT; st <= S_WLO; end
                   else begin idx <= idx + 1'b1; st <= S_WLO; end
            K_DAT: begin
              first_q <= 1'b0;
              if (last_q) begin kind <= K_C10; st <= S_WLO; end
              else st <= S_DWAIT;
            end
            K_C10: st <= S_WB;
            K_C70: st <= S_RLO;
            default: begin result_q <= RES_TMO; st <= S_DONE; end
          endcase
        end
        S_DWAIT: if (din_valid) begin
          byte_q <= din_data;
          last_q <= din_last;
          if (din_jump && !first_q) begin
            col_q <= din_col;
            kind  <= K_C85;
            idx   <= '0;
          end else kind <= K_DAT;
          st <= S_WLO;
        end
        S_WB: if (int'(cnt) >= WB_CYC - 1) begin
          cnt <= '0;
          tmo <= '0;
          st  <= S_BUSY;
        end else cnt <= cnt + 1'b1;
        S_BUSY: begin
          tmo <= tmo + 1'b1;
          if (nand_rb_n) begin kind <= K_C70; st <= S_WLO; end
          else if (tmo_hit) begin kind <= K_CFF; st <= S_WLO; end
        end
        S_RLO: begin
          tmo <= tmo + 1'b1;
          if (lo_end) begin
            cnt   <= '0;
            rdy_q <= nand_io_in[6];
            err_q <= nand_io_in[0];
            st    <= S_RHI;
          end else cnt <= cnt + 1'b1;
        end
        S_RHI: begin
          tmo <= tmo + 1'b1;
          if (!hi_end) cnt <= cnt + 1'b1;
          else begin
            cnt <= '0;
            if (rdy_q) begin
              result_q <= err_q ? RES_FAIL : RES_PASS;
              st       <= S_DONE;
            end else if (tmo_hit) begin
              kind <= K_CFF;
              st   <= S_WLO;
            end else st <= S_RLO;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module nand_prog_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       done,
  input logic       nand_ce_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       nand_io_oe,
  input logic [7:0] nand_io_out
);
  logic we_q, data_seen, post_conf, we_rise, is_cmd_latch;

  assign we_rise      = nand_we_n && !we_q;
  assign is_cmd_latch = we_rise && nand_cle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q      <= 1'b1;
      data_seen <= 1'b0;
      post_conf <= 1'b0;
    end else begin
      we_q <= nand_we_n;
      if (done || (is_cmd_latch && nand_io_out == 8'h80)) data_seen <= 1'b0;
      else if (we_rise && !nand_cle && !nand_ale) data_seen <= 1'b1;
      if (done) post_conf <= 1'b0;
      else if (is_cmd_latch && nand_io_out == 8'h10) post_conf <= 1'b1;
    end
  end

  assert_cle_ale_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  assert_confirm_needs_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd_latch && nand_io_out == 8'h10) |-> data_seen);
  assert_busy_cmds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cmd_latch && post_conf) |-> (nand_io_out == 8'h70 || nand_io_out == 8'hFF));
  assert_ce_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> nand_ce_n);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_release_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_io_oe);
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
endmodule

bind nand_prog_seq nand_prog_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
  .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_oe(nand_io_oe),
  .nand_io_out(nand_io_out)
);

// File: tb/tb_nand_prog_seq.sv
`timescale 1ns/1ps
module tb_nand_prog_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_row = '0;
  logic [15:0] req_col = '0;
  logic        din_valid = 1'b0;
  logic        din_ready;
  logic [7:0]  din_data = '0;
  logic [15:0] din_col = '0;
  logic        din_jump = 1'b0;
  logic        din_last = 1'b0;
  logic [5:0]  cfg_lo = 6'd1;
  logic [5:0]  cfg_hi = 6'd1;
  logic [19:0] cfg_tmo = 20'd1000;
  logic        done;
  logic [1:0]  result;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0]  nand_io_out;
  logic [7:0]  nand_io_in;
  logic        rb = 1'b1;

  always #4 clk = ~clk;

  nand_prog_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .din_valid(din_valid), .din_ready(din_ready),
    .din_data(din_data), .din_col(din_col), .din_jump(din_jump), .din_last(din_last),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_tmo(cfg_tmo), .done(done), .result(result),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
    .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rb_n(rb)
  );

  int compared = 0, mismatched = 0, cyc = 0;
  logic [9:0]  exp_q[$];
  logic [25:0] beat_q[$];
  int nbeat = 0;
  int busy_len = 5, busy_left = 0, rdy_lag = 0, reads_done = 0, re_pulses = 0;
  logic dev_fail = 1'b0;
  int we_w = 0, re_w = 0;
  logic we_prev = 1'b1, re_prev = 1'b1, take = 1'b0;
  logic pv = 1'b0, pr = 1'b0, busy_m = 1'b0;

  assign nand_io_in = {1'b0, (reads_done >= rdy_lag), 5'b0, dev_fail};

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
    end
  endtask

  function automatic int eff(input logic [5:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      summary();
    end
  end

  // device model and per-clock comparison
  always @(negedge clk) begin
    if (rst_n) begin
      take = din_valid && din_ready;
      if (pv && pr) busy_m = 1'b1;
      if (done) busy_m = 1'b0;
      chk(nand_ce_n == !busy_m, "R8", "CE# vs model", nand_ce_n, !busy_m);
      pv = req_valid;
      pr = req_ready;
      if (!nand_we_n) we_w++;
      if (nand_we_n && !we_prev) begin
        chk(we_w == eff(cfg_lo), "R2", "WE# low width", we_w, eff(cfg_lo));
        if (exp_q.size() == 0)
          chk(1'b0, "R1", "unexpected bus byte", {nand_cle, nand_ale, nand_io_out}, 0);
        else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          chk({nand_cle, nand_ale, nand_io_out} == e, "R1", "latched byte {cle,ale,io}",
              {nand_cle, nand_ale, nand_io_out}, e);
        end
        if (nand_cle && nand_io_out == 8'h10) begin rb = 1'b0; busy_left = busy_len; end
        if (nand_cle && nand_io_out == 8'hFF) rb = 1'b1;
        we_w = 0;
      end
      if (!nand_re_n) re_w++;
      if (nand_re_n && !re_prev) begin
        chk(re_w == eff(cfg_lo), "R6", "RE# low width", re_w, eff(cfg_lo));
        re_pulses++;
        reads_done++;
        re_w = 0;
      end
      if (!rb && busy_left > 0) begin
        busy_left--;
        if (busy_left == 0) rb = 1'b1;
      end
      we_prev = nand_we_n;
      re_prev = nand_re_n;
    end
  end

  // data stream feeder
  always @(posedge clk) begin
    #1;
    if (take) begin void'(beat_q.pop_front()); take = 1'b0; end
    if (beat_q.size() > 0) begin
      {din_last, din_jump, din_col, din_data} = beat_q[0];
      din_valid = 1'b1;
    end else din_valid = 1'b0;
  end

  task automatic start_exp(input logic [23:0] row, input logic [15:0] col);
    nbeat = 0;
    exp_q.push_back({2'b10, 8'h80});
    exp_q.push_back({2'b01, col[7:0]});
    exp_q.push_back({2'b01, col[15:8]});
    exp_q.push_back({2'b01, row[7:0]});
    exp_q.push_back({2'b01, row[15:8]});
    exp_q.push_back({2'b01, row[23:16]});
  endtask

  task automatic add_beat(input logic [7:0] d, input logic [15:0] c, input bit j, input bit l);
    if (j && nbeat > 0) begin
      exp_q.push_back({2'b10, 8'h85});
      exp_q.push_back({2'b01, c[7:0]});
      exp_q.push_back({2'b01, c[15:8]});
    end
    exp_q.push_back({2'b00, d});
    if (l) exp_q.push_back({2'b10, 8'h10});
    beat_q.push_back({l, j, c, d});
    nbeat++;
  endtask

  task automatic run_op(input logic [23:0] row, input logic [15:0] col,
                        input bit timeout_case, input bit poke,
                        input logic [1:0] exp_res, input string rq);
    int waitc;
    exp_q.push_back(timeout_case ? {2'b10, 8'hFF} : {2'b10, 8'h70});
    reads_done = 0;
    re_pulses = 0;
    @(posedge clk); #1;
    req_valid = 1'b1; req_row = row; req_col = col;
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (poke) begin
      repeat (20) @(posedge clk);
      #1; req_valid = 1'b1; req_row = 24'h123456; req_col = 16'h0777;
      repeat (5) @(posedge clk);
      #1; req_valid = 1'b0;
    end
    waitc = 0;
    @(negedge clk);
    while (!done && waitc < 20000) begin @(negedge clk); waitc++; end
    chk(done == 1'b1, rq, "done seen", done, 1);
    chk(result == exp_res, rq, "result code", result, exp_res);
    chk(re_pulses == (timeout_case ? 0 : rdy_lag + 1), "R6", "status read strobes",
        re_pulses, timeout_case ? 0 : rdy_lag + 1);
    @(negedge clk);
    chk(done == 1'b0 && req_ready == 1'b1, "R8", "single done then idle", {done, req_ready}, 2'b01);
    chk(exp_q.size() == 0, rq, "bus bytes left unseen", exp_q.size(), 0);
    exp_q.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && nand_ce_n && nand_we_n && nand_re_n && !nand_io_oe && !done, "R10",
        "reset outputs", {req_ready, nand_ce_n, nand_we_n, nand_re_n, nand_io_oe, done}, 6'b111100);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R4: plain load, pass
    cfg_lo = 6'd2; cfg_hi = 6'd1; busy_len = 10; rdy_lag = 0; dev_fail = 1'b0;
    start_exp(24'hA1B2C3, 16'h0102);
    add_beat(8'h11, 16'h0, 1'b0, 1'b0);
    add_beat(8'h22, 16'h0, 1'b0, 1'b0);
    add_beat(8'h33, 16'h0, 1'b0, 1'b1);
    run_op(24'hA1B2C3, 16'h0102, 1'b0, 1'b0, 2'd0, "R4");

    // R3: first-beat jump ignored, two jumps, fail status after two not-ready polls (R6)
    cfg_lo = 6'd1; cfg_hi = 6'd3; busy_len = 6; rdy_lag = 2; dev_fail = 1'b1;
    start_exp(24'h00FF10, 16'h0040);
    add_beat(8'hC0, 16'h1234, 1'b1, 1'b0);
    add_beat(8'hC1, 16'h0, 1'b0, 1'b0);
    add_beat(8'hC2, 16'h21DE, 1'b1, 1'b0);
    add_beat(8'hC3, 16'h0, 1'b0, 1'b0);
    add_beat(8'hC4, 16'h0005, 1'b1, 1'b1);
    run_op(24'h00FF10, 16'h0040, 1'b0, 1'b0, 2'd1, "R3");

    // R2: zero widths act as one, single last beat
    cfg_lo = 6'd0; cfg_hi = 6'd0; busy_len = 3; rdy_lag = 0; dev_fail = 1'b0;
    start_exp(24'h010203, 16'h2000);
    add_beat(8'h5A, 16'hFFFF, 1'b1, 1'b1);
    run_op(24'h010203, 16'h2000, 1'b0, 1'b0, 2'd0, "R2");

    // R7: device never ready
    cfg_lo = 6'd1; cfg_hi = 6'd1; cfg_tmo = 20'd50; busy_len = -1; rdy_lag = 0;
    start_exp(24'h777777, 16'h0001);
    add_beat(8'h99, 16'h0, 1'b0, 1'b0);
    add_beat(8'h98, 16'h0, 1'b0, 1'b1);
    run_op(24'h777777, 16'h0001, 1'b1, 1'b0, 2'd2, "R7");

    // R8: request raised mid-operation has no effect
    cfg_lo = 6'd2; cfg_hi = 6'd2; cfg_tmo = 20'd1000; busy_len = 20; dev_fail = 1'b0;
    start_exp(24'h0A0B0C, 16'h0300);
    for (int i = 0; i < 12; i++) add_beat(8'(i * 7 + 1), 16'h0, 1'b0, i == 11);
    run_op(24'h0A0B0C, 16'h0300, 1'b0, 1'b1, 2'd0, "R8");

    summary();
  end
endmodule